// File: doc/BRIEF.md
# Macro Operation Expansion Sequencer

This block takes one compound request (absolute value, or rotate-left by an amount held in a register) together with its register numbers. It then issues the equivalent run of plain three-address operations, one per cycle. Each issued operation is presented as decoded fields: an operation code, a destination, two sources, an immediate and a branch target label. A step index and a final-beat flag travel with every beat.

Both sides use a valid/ready handshake. A request is taken only while the sequencer is idle. The sequencer stays busy until the final operation of the current expansion has been handed off. The rotate expansion needs an intermediate value, which it keeps in a reserved scratch register (register 1 by default). Any request code that has no expansion is forwarded as a single raw operation. Whatever consumes the operations is outside this block.

Top module: `mexp_seq`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A request is accepted only on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the accepting edge until the edge that hands off the final operation, and it is 1 again in the following cycle. Requests offered while busy have no effect on the operations issued.
- R3: Request code 0 (absolute value) issues four operations in this order. Step 0: opcode 1 (branch if ≥ 0), rs=src, label 1. Step 1: opcode 2 (subtract), rd=dst, rs=0, rt=src. Step 2: opcode 3 (jump), label 2. Step 3: opcode 4 (add), rd=dst, rs=0, rt=src. Fields not named here are 0.
- R4: Request code 1 (rotate left) issues five operations in this order. Step 0: opcode 5 (add immediate), rd=S, rs=0, imm=32. Step 1: opcode 2, rd=S, rs=S, rt=amt. Step 2: opcode 6 (shift right logical by register), rd=S, rs=src, rt=S. Step 3: opcode 7 (shift left by register), rd=dst, rs=src, rt=amt. Step 4: opcode 8 (or), rd=dst, rs=dst, rt=S. Fields not named here are 0.
- R5: The scratch register S is register 1. It is the only register written by the rotate expansion besides dst, and every add-immediate carries the word width 32 in imm.
- R6: Request codes 2 and 3 issue one operation with opcode 9, rd=dst, rs=src, rt=amt, imm 0 and label 0, with out_last set.
- R7: out_step is 0 on the first beat of each expansion and rises by one on each handoff. out_last is 1 only on the final step.
- R8: While out_valid is 1 and out_ready is 0, every output field holds its value and out_valid stays 1.
- R9: The first beat appears in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Sequencer idle, request can be taken |
| in_kind | input | 2 | Request code (0 abs, 1 rotate left, others raw) |
| in_dst | input | 5 | Destination register |
| in_src | input | 5 | Source register |
| in_amt | input | 5 | Rotate amount register |
| out_valid | output | 1 | Operation presented |
| out_ready | input | 1 | Consumer takes the operation |
| out_op | output | 4 | Operation code |
| out_rd | output | 5 | Destination register |
| out_rs | output | 5 | First source register |
| out_rt | output | 5 | Second source register |
| out_imm | output | 16 | Immediate |
| out_label | output | 2 | Branch/jump target label (0 none, 1 pos, 2 out) |
| out_step | output | 3 | Step index within the expansion |
| out_last | output | 1 | Final operation of the expansion |

## Verification
The assertions check the handshake rules on every cycle:
- fields hold under backpressure;
- no request is taken while busy;
- the step advances by one per handoff;
- the sequencer returns to idle after the final beat;
- the first beat follows acceptance;
- the branch carries the forward label;
- the add-immediate targets the scratch register with the word width.

Only the bench scenarios can show the following:
- the exact order and field contents of each expansion;
- the raw forwarding of unsupported codes;
- that requests offered while busy leave the issued stream unchanged.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_BGEZ = 4'd1,
    OP_SUB  = 4'd2,
    OP_JMP  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADDI = 4'd5,
    OP_SRLV = 4'd6,
    OP_SLLV = 4'd7,
    OP_OR   = 4'd8,
    OP_RAW  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    K_ABS  = 2'd0,
    K_ROTL = 2'd1
  } kind_e;

  typedef enum logic [1:0] {
    L_NONE = 2'd0,
    L_POS  = 2'd1,
    L_OUT  = 2'd2
  } label_e;

  localparam int ABS_STEPS  = 4;
  localparam int ROTL_STEPS = 5;

endpackage

// File: rtl/mexp_expand.sv
module mexp_expand
  import mexp_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int IMM_W     = 16,
  parameter int STEP_W    = 3,
  parameter int KIND_W    = 2,
  parameter int SCRATCH   = 1,
  parameter int WORD_BITS = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [STEP_W-1:0] step,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src,
  input  logic [REG_W-1:0]  amt,
  output logic [3:0]        op,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  rs,
  output logic [REG_W-1:0]  rt,
  output logic [IMM_W-1:0]  imm,
  output logic [1:0]        label,
  output logic              last
);

  localparam logic [REG_W-1:0] R0 = '0;
  localparam logic [REG_W-1:0] RS = REG_W'(SCRATCH);
  localparam logic [IMM_W-1:0] WIDTH_IMM = IMM_W'(WORD_BITS);

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [IMM_W-1:0] imm;
    label_e           label;
    logic             last;
  } beat_t;

  function automatic beat_t mk(op_e o, logic [REG_W-1:0] d, logic [REG_W-1:0] a,
                               logic [REG_W-1:0] b, logic [IMM_W-1:0] i, label_e l, logic f);
    beat_t t;
    t.op = o; t.rd = d; t.rs = a; t.rt = b; t.imm = i; t.label = l; t.last = f;
    return t;
  endfunction

  function automatic beat_t expand_abs(logic [STEP_W-1:0] s, logic [REG_W-1:0] d,
                                       logic [REG_W-1:0] x);
    case (s)
      STEP_W'(0): return mk(OP_BGEZ, R0, x,  R0, '0, L_POS,  1'b0);
      STEP_W'(1): return mk(OP_SUB,  d,  R0, x,  '0, L_NONE, 1'b0);
      STEP_W'(2): return mk(OP_JMP,  R0, R0, R0, '0, L_OUT,  1'b0);
      STEP_W'(ABS_STEPS-1): return mk(OP_ADD, d, R0, x, '0, L_NONE, 1'b1);
      default:    return mk(OP_NOP,  R0, R0, R0, '0, L_NONE, 1'b1);
    endcase
  endfunction

  function automatic beat_t expand_rotl(logic [STEP_W-1:0] s, logic [REG_W-1:0] d,
                                        logic [REG_W-1:0] x, logic [REG_W-1:0] n);
    case (s)
      STEP_W'(0): return mk(OP_ADDI, RS, R0, R0, WIDTH_IMM, L_NONE, 1'b0);
      STEP_W'(1): return mk(OP_SUB,  RS, RS, n,  '0, L_NONE, 1'b0);
      STEP_W'(2): return mk(OP_SRLV, RS, x,  RS, '0, L_NONE, 1'b0);
      STEP_W'(3): return mk(OP_SLLV, d,  x,  n,  '0, L_NONE, 1'b0);
      STEP_W'(ROTL_STEPS-1): return mk(OP_OR, d, d, RS, '0, L_NONE, 1'b1);
      default:    return mk(OP_NOP,  R0, R0, R0, '0, L_NONE, 1'b1);
    endcase
  endfunction

  beat_t b;

  always_comb begin
    case (kind)
      KIND_W'(K_ABS):  b = expand_abs(step, dst, src);
      KIND_W'(K_ROTL): b = expand_rotl(step, dst, src, amt);
      default:         b = mk(OP_RAW, dst, src, amt, '0, L_NONE, 1'b1);
    endcase
  end

  assign op    = b.op;
  assign rd    = b.rd;
  assign rs    = b.rs;
  assign rt    = b.rt;
  assign imm   = b.imm;
  assign label = b.label;
  assign last  = b.last;

endmodule

// File: rtl/mexp_ctrl.sv
module mexp_ctrl #(
  parameter int REG_W  = 5,
  parameter int STEP_W = 3,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src,
  input  logic [REG_W-1:0]  in_amt,
  input  logic              out_ready,
  input  logic              step_last,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic [KIND_W-1:0] kind_q,
  output logic [REG_W-1:0]  dst_q,
  output logic [REG_W-1:0]  src_q,
  output logic [REG_W-1:0]  amt_q,
  output logic              take_ev,
  output logic              hand_ev,
  output logic              done_ev
);

  assign take_ev = in_valid && !busy;
  assign hand_ev = busy && out_ready;
  assign done_ev = hand_ev && step_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      kind_q <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      amt_q  <= '0;
    end else if (take_ev) begin
      busy   <= 1'b1;
      step   <= '0;
      kind_q <= in_kind;
      dst_q  <= in_dst;
      src_q  <= in_src;
      amt_q  <= in_amt;
    end else if (done_ev) begin
      busy <= 1'b0;
      step <= '0;
    end else if (hand_ev) begin
      step <= step + STEP_W'(1);
    end
  end

  // R2: nothing is latched while a sequence is running
  assert_latch_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_ev) |=> ($stable(kind_q) && $stable(dst_q) && $stable(src_q) && $stable(amt_q)));

  // R9: an accepted request is presented on the next cycle at step 0
  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> (busy && step == '0));

endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int IMM_W     = 16,
  parameter int STEP_W    = 3,
  parameter int KIND_W    = 2,
  parameter int SCRATCH   = 1,
  parameter int WORD_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src,
  input  logic [REG_W-1:0]  in_amt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_op,
  output logic [REG_W-1:0]  out_rd,
  output logic [REG_W-1:0]  out_rs,
  output logic [REG_W-1:0]  out_rt,
  output logic [IMM_W-1:0]  out_imm,
  output logic [1:0]        out_label,
  output logic [STEP_W-1:0] out_step,
  output logic              out_last
);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [KIND_W-1:0] kind_q;
  logic [REG_W-1:0]  dst_q, src_q, amt_q;
  logic              take_ev, hand_ev, done_ev;
  logic              step_last;

  mexp_ctrl #(.REG_W(REG_W), .STEP_W(STEP_W), .KIND_W(KIND_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_dst(in_dst), .in_src(in_src), .in_amt(in_amt), .out_ready(out_ready),
    .step_last(step_last), .busy(busy), .step(step), .kind_q(kind_q),
    .dst_q(dst_q), .src_q(src_q), .amt_q(amt_q),
    .take_ev(take_ev), .hand_ev(hand_ev), .done_ev(done_ev)
  );

  mexp_expand #(.REG_W(REG_W), .IMM_W(IMM_W), .STEP_W(STEP_W), .KIND_W(KIND_W),
                .SCRATCH(SCRATCH), .WORD_BITS(WORD_BITS)) expand_i (
    .kind(kind_q), .step(step), .dst(dst_q), .src(src_q), .amt(amt_q),
    .op(out_op), .rd(out_rd), .rs(out_rs), .rt(out_rt), .imm(out_imm),
    .label(out_label), .last(step_last)
  );

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_step  = step;
  assign out_last  = step_last;

  // R8: backpressure holds the beat
  assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd) &&
      $stable(out_rs) && $stable(out_rt) && $stable(out_imm) && $stable(out_label) &&
      $stable(out_step) && $stable(out_last)));

  // R7: each non-final handoff moves to the next step
  assert_step_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_step == $past(out_step) + STEP_W'(1)));

  // R2: after the final handoff the sequencer is idle again
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  // R2: input side is closed while operations are pending
  assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5: the add-immediate always loads the scratch register with the word width
  assert_scratch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 4'(OP_ADDI)) |->
      (out_rd == REG_W'(SCRATCH) && out_imm == IMM_W'(WORD_BITS)));

  // R3: the conditional branch targets the forward label
  assert_branch_label_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 4'(OP_BGEZ)) |-> (out_label == 2'(L_POS) && !out_last));

endmodule

// File: tb/mexp_seq_tb.sv
module mexp_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = '0;
  logic [4:0] in_dst = '0, in_src = '0, in_amt = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [3:0] out_op;
  logic [4:0] out_rd, out_rs, out_rt;
  logic [15:0] out_imm;
  logic [1:0] out_label;
  logic [2:0] out_step;
  logic out_last;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mexp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_dst(in_dst), .in_src(in_src), .in_amt(in_amt),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_rd(out_rd), .out_rs(out_rs), .out_rt(out_rt), .out_imm(out_imm),
    .out_label(out_label), .out_step(out_step), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [36:0] pk(int op, int rd, int rs, int rt, int imm, int lb);
    return {4'(op), 5'(rd), 5'(rs), 5'(rt), 16'(imm), 2'(lb)};
  endfunction

  // expected beats restated from R3, R4, R6 (scratch register 1 from R5)
  function automatic logic [36:0] want(int k, int i, int d, int s, int a);
    if (k == 0) begin
      if (i == 0) return pk(1, 0, s, 0, 0, 1);
      if (i == 1) return pk(2, d, 0, s, 0, 0);
      if (i == 2) return pk(3, 0, 0, 0, 0, 2);
      return pk(4, d, 0, s, 0, 0);
    end
    if (k == 1) begin
      case (i)
        0: return pk(5, 1, 0, 0, 32, 0);
        1: return pk(2, 1, 1, a, 0, 0);
        2: return pk(6, 1, s, 1, 0, 0);
        3: return pk(7, d, s, a, 0, 0);
        default: return pk(8, d, d, 1, 0, 0);
      endcase
    end
    return pk(9, d, s, a, 0, 0);
  endfunction

  function automatic int beats(int k);
    return (k == 0) ? 4 : (k == 1) ? 5 : 1;
  endfunction

  task automatic look(input int k, input int i, input int d, input int s, input int a, input string rq);
    logic [36:0] got, exp;
    got = {out_op, out_rd, out_rs, out_rt, out_imm, out_label};
    exp = want(k, i, d, s, a);
    chk(out_valid === 1'b1, rq, 64'(out_valid), 64'd1);
    chk(got === exp, rq, 64'(got), 64'(exp));
    chk(out_step === 3'(i), "R7 step", 64'(out_step), 64'(i));
    chk(out_last === (i == beats(k) - 1), "R7 last", 64'(out_last), 64'(i == beats(k) - 1));
  endtask

  task automatic run_macro(input int k, input int d, input int s, input int a,
                           input bit stall, input bit intrude, input string rq);
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_kind = 2'(k); in_dst = 5'(d); in_src = 5'(s); in_amt = 5'(a);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R9 first beat", 64'(out_valid), 64'd1);
    for (int i = 0; i < beats(k); i++) begin
      if (intrude && i < beats(k) - 1) begin
        in_valid = 1'b1; in_kind = 2'(k ^ 1); in_dst = 5'd30; in_src = 5'd29; in_amt = 5'd28;
        chk(in_ready === 1'b0, "R2 busy", 64'(in_ready), 64'd0);
      end else begin
        in_valid = 1'b0;
      end
      if (stall) begin
        out_ready = 1'b0;
        look(k, i, d, s, a, rq);
        @(posedge clk);
        @(negedge clk);
        look(k, i, d, s, a, "R8 hold");
      end
      look(k, i, d, s, a, rq);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
    end
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R2 done", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R2 reopen", 64'(in_ready), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_abs;
    run_macro(0, 2, 3, 0, 1'b0, 1'b0, "R3 abs");
    run_macro(0, 31, 17, 9, 1'b0, 1'b0, "R3 abs");
  endtask

  task automatic t_rotl;
    run_macro(1, 2, 3, 4, 1'b0, 1'b0, "R4 rotl");
    run_macro(1, 20, 11, 6, 1'b0, 1'b0, "R5 rotl scratch");
  endtask

  task automatic t_raw;
    run_macro(2, 5, 6, 7, 1'b0, 1'b0, "R6 raw");
    run_macro(3, 25, 14, 3, 1'b0, 1'b0, "R6 raw");
  endtask

  task automatic t_stall;
    run_macro(1, 8, 9, 10, 1'b1, 1'b0, "R8 rotl stall");
    run_macro(0, 12, 13, 0, 1'b1, 1'b0, "R8 abs stall");
  endtask

  task automatic t_intrude;
    run_macro(0, 4, 5, 6, 1'b0, 1'b1, "R2 abs intruded");
    run_macro(1, 7, 8, 9, 1'b1, 1'b1, "R2 rotl intruded");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_abs();
    t_rotl();
    t_raw();
    t_stall();
    t_intrude();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule